// File: doc/BRIEF.md
# Key-guarded configuration table write lock

This block sits on a 32-bit register write bus (address, data, write strobe) in front of a protected configuration table, such as a sequence or instruction table held in an external array. It owns the lock state of that table. While the table is open, bus writes that fall in the table window pass straight through to the array's write port with a word index. While it is locked, such writes are dropped and a sticky violation flag records the attempt.

Changing the lock state is a two-step protocol. Software first writes a fixed 32-bit key (0x5AF05AF0) to the key register, which arms a one-shot permission. The very next bus write must be to the lock-control register; code 0x2 opens the table, code 0x1 closes it. Any other write in between, including a wrong key, cancels the permission, so one stray write can never change the lock state. The usual flow is: key, open, write the table words, key, close.

A combinational read port returns a status word and the current lock code. Reads never disturb the armed key.

Top module: `wlk_guard`

## Requirements
- R1: After reset the table is locked, the violation flag is clear and no key is armed: the status word (offset 0x020) reads 0x1 and the lock-control register (offset 0x01C) reads 0x1.
- R2: A write of exactly 0x5AF05AF0 to the key register (offset 0x018) arms the key; status bit 2 reads 1 from the next cycle on.
- R3: With the key armed, a lock-control write of 0x2 opens the table and 0x1 locks it; status bit 0 (1 = locked) and the lock-control readback (0x1 locked, 0x2 open) follow from the next cycle.
- R4: A lock-control write without an armed key leaves the lock state unchanged.
- R5: Every write other than a correct key write disarms the key, including a key write with any other value; reads do not disarm it.
- R6: A lock-control write of any value other than 0x1 or 0x2 leaves the lock state unchanged but consumes the armed key.
- R7: While open, a write to the table window (byte offsets 0x200 to 0x3FF) raises tbl_we in the same cycle, with tbl_idx = (address - 0x200) / 4 (low two address bits ignored) and tbl_wdata equal to the written data.
- R8: While locked, a table-window write keeps tbl_we low and sets the violation flag (status bit 1) from the next cycle; the flag stays set.
- R9: Writing the status register with bit 1 set clears the violation flag; a status write with bit 1 clear leaves it unchanged.
- R10: Writes outside the table window never raise tbl_we; reads of addresses other than status and lock-control return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | ADDR_W | Bus write byte address |
| wr_data | input | 32 | Bus write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Read data (status or lock code) |
| tbl_we | output | 1 | Write enable to the external table array |
| tbl_idx | output | IDX_W | Word index into the table |
| tbl_wdata | output | 32 | Write data to the table |
| locked | output | 1 | Current lock state, 1 = locked |

## Verification
The bench builds the block with its default parameters: a 12-bit address space and a 128-word table window. That size lets every table word be written once while locked and once while open, with index and data computed arithmetically, and the 32-bit key lets all 32 single-bit corruptions of the key be tried against a following lock command. Lock-control codes 0 to 7 and two wide values are swept with the key armed, and the key is separated from its command by both a write and a read.

// File: rtl/wlk_pkg.sv
package wlk_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_LOCK = 2'd1,
    CMD_OPEN = 2'd2
  } wlk_cmd_e;

  typedef enum logic {
    ST_OPEN   = 1'b0,
    ST_LOCKED = 1'b1
  } wlk_state_e;

  localparam int unsigned STAT_LOCK_BIT = 0;
  localparam int unsigned STAT_VIOL_BIT = 1;
  localparam int unsigned STAT_ARM_BIT  = 2;

  // Byte address a lies inside a window of 'words' 32-bit words at 'base'.
  function automatic logic f_in_window(input logic [31:0] a, input logic [31:0] base,
                                       input int unsigned words);
    return (a >= base) && (a < base + words * 4);
  endfunction

  // Word index of byte address a relative to base.
  function automatic logic [31:0] f_word_index(input logic [31:0] a, input logic [31:0] base);
    return (a - base) >> 2;
  endfunction

  // Two byte addresses refer to the same 32-bit register.
  function automatic logic f_same_word(input logic [31:0] a, input logic [31:0] b);
    return a[31:2] == b[31:2];
  endfunction

  function automatic wlk_cmd_e f_decode_cmd(input logic [31:0] d, input logic [31:0] lock_code,
                                            input logic [31:0] open_code);
    if (d == lock_code) return CMD_LOCK;
    if (d == open_code) return CMD_OPEN;
    return CMD_NONE;
  endfunction

endpackage

// File: rtl/wlk_addr_dec.sv
module wlk_addr_dec
  import wlk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned KEY_OFS   = 'h018,
  parameter int unsigned CTRL_OFS  = 'h01C,
  parameter int unsigned STAT_OFS  = 'h020,
  parameter int unsigned TBL_BASE  = 'h200,
  parameter int unsigned TBL_WORDS = 128,
  localparam int unsigned IDX_W    = $clog2(TBL_WORDS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_key,
  output logic              hit_ctrl,
  output logic              hit_stat,
  output logic              hit_tbl,
  output logic [IDX_W-1:0]  tbl_idx
);
  logic [31:0] a32;
  logic [31:0] idx32;

  assign a32      = 32'(addr);
  assign hit_key  = f_same_word(a32, 32'(KEY_OFS));
  assign hit_ctrl = f_same_word(a32, 32'(CTRL_OFS));
  assign hit_stat = f_same_word(a32, 32'(STAT_OFS));
  assign hit_tbl  = f_in_window(a32, 32'(TBL_BASE), TBL_WORDS);
  assign idx32    = f_word_index(a32, 32'(TBL_BASE));
  assign tbl_idx  = idx32[IDX_W-1:0];
endmodule

// File: rtl/wlk_key_arm.sv
module wlk_key_arm #(
  parameter logic [31:0] KEY_VAL = 32'h5AF0_5AF0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        hit_key,
  input  logic [31:0] wr_data,
  output logic        key_good,
  output logic        armed
);
  assign key_good = wr_en && hit_key && (wr_data == KEY_VAL);

  // Every write re-decides the armed bit: only a correct key leaves it set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed <= 1'b0;
    else if (wr_en) armed <= key_good;
  end
endmodule

// File: rtl/wlk_lock_fsm.sv
module wlk_lock_fsm
  import wlk_pkg::*;
#(
  parameter logic [31:0] LOCK_CODE = 32'h1,
  parameter logic [31:0] OPEN_CODE = 32'h2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        hit_ctrl,
  input  logic        armed,
  input  logic [31:0] wr_data,
  output logic        cmd_fire,
  output logic        locked
);
  wlk_cmd_e   cmd;
  wlk_state_e state_q, state_d;

  assign cmd      = f_decode_cmd(wr_data, LOCK_CODE, OPEN_CODE);
  assign cmd_fire = wr_en && hit_ctrl && armed;

  always_comb begin
    state_d = state_q;
    if (cmd_fire) begin
      case (cmd)
        CMD_LOCK: state_d = ST_LOCKED;
        CMD_OPEN: state_d = ST_OPEN;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_LOCKED;
    else        state_q <= state_d;
  end

  assign locked = (state_q == ST_LOCKED);
endmodule

// File: rtl/wlk_viol.sv
module wlk_viol (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic hit_tbl,
  input  logic hit_stat,
  input  logic clr_bit,
  input  logic locked,
  output logic pass_we,
  output logic blocked_evt,
  output logic clr_evt,
  output logic viol
);
  assign pass_we     = wr_en && hit_tbl && !locked;
  assign blocked_evt = wr_en && hit_tbl && locked;
  assign clr_evt     = wr_en && hit_stat && clr_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           viol <= 1'b0;
    else if (blocked_evt) viol <= 1'b1;
    else if (clr_evt)     viol <= 1'b0;
  end
endmodule

// File: rtl/wlk_guard.sv
module wlk_guard
  import wlk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned KEY_OFS   = 'h018,
  parameter int unsigned CTRL_OFS  = 'h01C,
  parameter int unsigned STAT_OFS  = 'h020,
  parameter int unsigned TBL_BASE  = 'h200,
  parameter int unsigned TBL_WORDS = 128,
  parameter logic [31:0] KEY_VAL   = 32'h5AF0_5AF0,
  parameter logic [31:0] LOCK_CODE = 32'h1,
  parameter logic [31:0] OPEN_CODE = 32'h2,
  localparam int unsigned IDX_W    = $clog2(TBL_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              tbl_we,
  output logic [IDX_W-1:0]  tbl_idx,
  output logic [31:0]       tbl_wdata,
  output logic              locked
);
  logic hit_key, hit_ctrl, hit_stat, hit_tbl;
  logic key_good, armed, cmd_fire;
  logic blocked_evt, clr_evt, viol;
  logic [31:0] status_word;
  logic [31:0] r32;

  wlk_addr_dec #(
    .ADDR_W(ADDR_W), .KEY_OFS(KEY_OFS), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS),
    .TBL_BASE(TBL_BASE), .TBL_WORDS(TBL_WORDS)
  ) u_dec (
    .addr(wr_addr), .hit_key(hit_key), .hit_ctrl(hit_ctrl), .hit_stat(hit_stat),
    .hit_tbl(hit_tbl), .tbl_idx(tbl_idx)
  );

  wlk_key_arm #(.KEY_VAL(KEY_VAL)) u_key (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hit_key(hit_key), .wr_data(wr_data),
    .key_good(key_good), .armed(armed)
  );

  wlk_lock_fsm #(.LOCK_CODE(LOCK_CODE), .OPEN_CODE(OPEN_CODE)) u_lock (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hit_ctrl(hit_ctrl), .armed(armed),
    .wr_data(wr_data), .cmd_fire(cmd_fire), .locked(locked)
  );

  wlk_viol u_viol (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hit_tbl(hit_tbl), .hit_stat(hit_stat),
    .clr_bit(wr_data[STAT_VIOL_BIT]), .locked(locked), .pass_we(tbl_we),
    .blocked_evt(blocked_evt), .clr_evt(clr_evt), .viol(viol)
  );

  assign tbl_wdata = wr_data;

  always_comb begin
    status_word                = '0;
    status_word[STAT_LOCK_BIT] = locked;
    status_word[STAT_VIOL_BIT] = viol;
    status_word[STAT_ARM_BIT]  = armed;
  end

  assign r32 = 32'(rd_addr);

  always_comb begin
    if (f_same_word(r32, 32'(STAT_OFS)))      rd_data = status_word;
    else if (f_same_word(r32, 32'(CTRL_OFS))) rd_data = locked ? LOCK_CODE : OPEN_CODE;
    else                                      rd_data = '0;
  end
endmodule

// File: rtl/wlk_guard_chk.sv
module wlk_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic hit_tbl,
  input logic key_good,
  input logic armed,
  input logic cmd_fire,
  input logic locked,
  input logic blocked_evt,
  input logic clr_evt,
  input logic viol,
  input logic tbl_we
);
  p_we_needs_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |-> (!locked && hit_tbl && wr_en));

  p_lock_moves_on_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |-> $past(cmd_fire));

  p_arm_from_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> $past(key_good));

  p_disarm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_good) |=> !armed);

  p_block_sets_viol_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_evt |=> viol);

  p_viol_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol) |-> $past(blocked_evt));

  p_viol_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !clr_evt) |=> viol);
endmodule

bind wlk_guard wlk_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .hit_tbl(hit_tbl), .key_good(key_good),
  .armed(armed), .cmd_fire(cmd_fire), .locked(locked), .blocked_evt(blocked_evt),
  .clr_evt(clr_evt), .viol(viol), .tbl_we(tbl_we)
);

// File: tb/wlk_guard_tb_top.sv
`timescale 1ns/1ps
module wlk_guard_tb_top;
  localparam int unsigned AW     = 12;
  localparam int unsigned IW     = 7;
  localparam int unsigned KEYA   = 'h018;
  localparam int unsigned CTRLA  = 'h01C;
  localparam int unsigned STATA  = 'h020;
  localparam int unsigned TBASE  = 'h200;
  localparam int unsigned TWORDS = 128;
  localparam logic [31:0] KV     = 32'h5AF0_5AF0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [31:0]   wr_data;
  logic [AW-1:0] rd_addr;
  logic [31:0]   rd_data;
  logic          tbl_we;
  logic [IW-1:0] tbl_idx;
  logic [31:0]   tbl_wdata;
  logic          locked;

  always #2.5 clk = ~clk;

  wlk_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_wdata(tbl_wdata), .locked(locked)
  );

  int checks = 0;
  int fails  = 0;
  bit m_locked, m_viol, m_armed;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status();
    return {29'b0, m_armed, m_viol, m_locked};
  endfunction

  task automatic rd_chk(input string req, input int unsigned a, input logic [31:0] exp);
    rd_addr = AW'(a);
    #1;
    chk(req, rd_data, exp);
  endtask

  // One bus write; checks the table port during the write and status after it.
  task automatic wr(input string req, input int unsigned a, input logic [31:0] d);
    bit in_tbl, exp_we, key_ok;
    in_tbl = (a >= TBASE) && (a < TBASE + TWORDS * 4);
    exp_we = in_tbl && !m_locked;
    key_ok = (a == KEYA) && (d == KV);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    #1;
    chk(req, 32'(tbl_we), 32'(exp_we));
    if (exp_we) begin
      chk(req, 32'(tbl_idx), (a - TBASE) / 4);
      chk(req, tbl_wdata, d);
    end
    if ((a == CTRLA) && m_armed) begin
      if (d == 32'h1) m_locked = 1'b1;
      else if (d == 32'h2) m_locked = 1'b0;
    end
    if (in_tbl && !exp_we) m_viol = 1'b1;
    else if ((a == STATA) && d[1]) m_viol = 1'b0;
    m_armed = key_ok;
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk(req, STATA, exp_status());
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    m_locked = 1'b1; m_viol = 1'b0; m_armed = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    rd_chk("R1 status", STATA, 32'h1);
    rd_chk("R1 ctrl", CTRLA, 32'h1);
    chk("R1 tbl_we", 32'(tbl_we), 32'h0);

    // R8 every table word blocked while locked
    for (int i = 0; i < TWORDS; i++)
      wr("R8", TBASE + i * 4 + (i % 4), 32'h0101_0101 * i ^ 32'hA5);

    // R9 clear behaviour
    wr("R9 no-clear", STATA, 32'h1);
    wr("R9 clear", STATA, 32'h2);

    // R2/R3 unlock
    wr("R2", KEYA, KV);
    wr("R3 open", CTRLA, 32'h2);
    rd_chk("R3 ctrl readback", CTRLA, 32'h2);

    // R7 every table word passes while open
    for (int i = 0; i < TWORDS; i++)
      wr("R7", TBASE + i * 4 + ((i + 1) % 4), 32'hC3C3_0000 + i * 32'h11);

    // R10 outside the window
    wr("R10", TBASE - 4, 32'h1234_5678);
    wr("R10", TBASE + TWORDS * 4, 32'h8765_4321);
    wr("R10", 0, 32'hFFFF_FFFF);
    rd_chk("R10 unmapped read", 'h004, 32'h0);

    // R4 command without key
    wr("R4", CTRLA, 32'h1);

    // R5 single-bit corrupted keys, each followed by a lock attempt
    for (int b = 0; b < 32; b++) begin
      wr("R5 bad key", KEYA, KV ^ (32'h1 << b));
      wr("R4 after bad key", CTRLA, 32'h1);
    end

    // R5 a write between key and command disarms
    wr("R2", KEYA, KV);
    wr("R5 intervening write", 0, 32'h0);
    wr("R5 stale command", CTRLA, 32'h1);

    // R5 a read between key and command does not disarm
    wr("R2", KEYA, KV);
    rd_chk("R5 read keeps arm", STATA, exp_status());
    rd_chk("R5 read ctrl", CTRLA, 32'h2);
    wr("R3 lock", CTRLA, 32'h1);
    rd_chk("R3 ctrl readback", CTRLA, 32'h1);

    // R8 table write between key and command: blocked, and disarms
    wr("R2", KEYA, KV);
    wr("R8 blocked", TBASE + 8, 32'hDEAD_BEEF);
    wr("R5 disarmed by table write", CTRLA, 32'h2);
    wr("R9 clear", STATA, 32'hFFFF_FFFF);

    // R6 sweep of command codes with the key armed each time
    for (int v = 0; v < 10; v++) begin
      logic [31:0] code;
      code = (v < 8) ? 32'(v) : ((v == 8) ? 32'h8000_0002 : 32'hFFFF_FFFF);
      wr("R2", KEYA, KV);
      wr("R6", CTRLA, code);
      if (code != 32'h1 && code != 32'h2) wr("R6 key consumed", CTRLA, m_locked ? 32'h2 : 32'h1);
    end

    // R4 second command after one accepted command
    wr("R2", KEYA, KV);
    wr("R3 open", CTRLA, 32'h2);
    wr("R4 reuse", CTRLA, 32'h1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule